// File: doc/BRIEF.md
# Keyboard Serial Receive Interface

This block takes asynchronous serial characters from a keyboard line and hands each one to a host as an 8-bit parallel byte. A receiver oversamples the line 16 times per bit and accepts a start bit only if the line is still low at the centre of that bit. It then samples eight data bits at their centres, least significant first. After the data it checks an even parity bit and a single stop bit.

Once a character has been assembled and its byte is stable, the receiver pulses a ready strobe. That strobe sets a data-ready latch. The latch holds until the host acknowledges the character. Parity and framing results are kept in flags next to the latch. The host reaches all of this through a bit-addressed port: each cycle it can read one input bit at `bit_addr` on `bit_rdata`, and it can write one output bit with `bit_wr`/`bit_wdata`. An active-low interrupt is asserted while the latch is set and the host has set its interrupt-enable bit.

The receiver is a state machine with these states: `ST_IDLE` (line idle, waiting for a falling edge), `ST_START` (counting to the middle of the start bit), `ST_DATA` (eight centre samples), `ST_PARITY` (parity sample), `ST_STOP` (stop sample and byte load), `ST_LOAD` (one settling cycle with the byte stable) and `ST_DONE` (ready strobe). Its transitions are:
- IDLE→START on a falling edge of the synchronised line.
- START→IDLE if the line is high at mid-bit, and START→DATA if it is low.
- DATA→PARITY after the eighth data sample.
- PARITY→STOP after the parity sample.
- STOP→LOAD after the stop sample.
- LOAD→DONE and DONE→IDLE unconditionally.

Top module: `kbd_serial_rx_if`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent least significant bit first, an even parity bit and one stop bit, with the line idling high. The data bits appear on `rx_byte[7:0]` with bit 0 being the first data bit sent.
- R2: The internal ready strobe is one clock long. It comes one cycle after `rx_byte` was loaded, so `rx_byte` is unchanged during the strobe.
- R3: The ready strobe sets `data_ready`. `data_ready` stays 1 after the strobe until an acknowledge write.
- R4: The read port maps input bits by address:
  - addresses 0 to 7 read `rx_byte` bits 0 to 7;
  - address 16 reads `data_ready`;
  - address 17 reads `parity_err`;
  - address 18 reads `frame_err`;
  - every other address reads 0.
- R5: `kbd_int_n` is 0 exactly when `data_ready` is 1 and the interrupt-enable bit is 1. Otherwise it is 1.
- R6: Writing output address 16 loads `bit_wdata` into the interrupt-enable bit, but only while the select bit is 0. The select bit is written at output address 15. A write to address 16 while the select bit is 1 leaves the enable unchanged.
- R7: With each new character, `parity_err` is loaded with 1 if the eight data bits and the parity bit together hold an odd number of ones, and with 0 otherwise.
- R8: Writing 1 to output address 17 clears `data_ready`, `parity_err` and `frame_err` on the next clock edge.
- R9: If a ready strobe and an acknowledge write fall in the same cycle, `data_ready` ends that cycle set.
- R10: A stop bit sampled low sets `frame_err`. The byte is still delivered and `data_ready` is still set.
- R11: A low pulse shorter than half a bit does not start a frame, and `data_ready` stays 0.
- R12: After reset, `data_ready`, `parity_err`, `frame_err`, the interrupt enable and the select bit are all 0, and `kbd_int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Asynchronous serial keyboard line, idles high |
| bit_addr | input | ADDR_W | Bit address for host reads and writes |
| bit_wr | input | 1 | Host write strobe for one output bit |
| bit_wdata | input | 1 | Value of the output bit being written |
| bit_rdata | output | 1 | Input bit selected by `bit_addr` |
| rx_byte | output | DATA_BITS | Last received character |
| data_ready | output | 1 | Data-ready latch |
| parity_err | output | 1 | Parity error of the last character |
| frame_err | output | 1 | Framing error of the last character |
| kbd_int_n | output | 1 | Active-low interrupt |

## Verification
Host writes take effect at the first rising edge after the strobe. `bit_rdata` and `kbd_int_n` are combinational, so they follow that edge within the same cycle.

A character's results land a few cycles after the centre of its stop bit: two synchroniser stages, up to one tick of divider phase, then the load, settle and strobe cycles. The bench therefore checks each character only after it has driven the whole stop bit, at a falling clock edge. Read-port checks set the address at a falling edge and sample shortly after it.

The same-cycle acknowledge case holds the acknowledge write for the whole stop bit. It then looks, at each falling edge, for the one cycle in which `data_ready` is set.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_LOAD,
        ST_DONE
    } rx_state_t;

    // Host input bit addresses (read side)
    localparam int IN_RDY_BIT   = 16;
    localparam int IN_PERR_BIT  = 17;
    localparam int IN_FERR_BIT  = 18;

    // Host output bit addresses (write side)
    localparam int OUT_SEL_BIT  = 15;
    localparam int OUT_IEN_BIT  = 16;
    localparam int OUT_ACK_BIT  = 17;

endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/kbd_rx_baud.sv
module kbd_rx_baud #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/kbd_rx_core.sv
module kbd_rx_core
    import kbd_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 tick,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_perr,
    output logic                 rx_ferr,
    output logic                 rx_ready
);

    localparam int OW   = $clog2(OVS);
    localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [OW-1:0] MID  = OW'(OVS / 2 - 1);
    localparam logic [OW-1:0] LAST = OW'(OVS - 1);
    localparam logic [IW-1:0] TOP  = IW'(DATA_BITS - 1);

    rx_state_t            state_q, state_d;
    logic [OW-1:0]        cnt_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] byte_q;
    logic                 par_q;
    logic                 perr_q;
    logic                 ferr_q;
    logic                 rxd_prev_q;
    logic                 fall;
    logic                 at_mid;
    logic                 at_centre;

    assign fall      = rxd_prev_q && !rxd;
    assign at_mid    = tick && (cnt_q == MID);
    assign at_centre = tick && (cnt_q == LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fall) state_d = ST_START;
            ST_START:  if (at_mid) state_d = rxd ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_centre && idx_q == TOP) state_d = ST_PARITY;
            ST_PARITY: if (at_centre) state_d = ST_STOP;
            ST_STOP:   if (at_centre) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            shift_q    <= '0;
            byte_q     <= '0;
            par_q      <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            rxd_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            rxd_prev_q <= rxd;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
                par_q <= 1'b0;
            end else if (tick) begin
                if (at_centre || (state_q == ST_START && at_mid)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + OW'(1);
                end
            end
            if (state_q == ST_DATA && at_centre) begin
                shift_q <= {rxd, shift_q[DATA_BITS-1:1]};
                idx_q   <= idx_q + IW'(1);
                par_q   <= par_q ^ rxd;
            end
            if (state_q == ST_PARITY && at_centre) begin
                par_q <= par_q ^ rxd;
            end
            if (state_q == ST_STOP && at_centre) begin
                byte_q <= shift_q;
                perr_q <= par_q;
                ferr_q <= !rxd;
            end
        end
    end

    // Outputs
    always_comb begin
        rx_byte  = byte_q;
        rx_perr  = perr_q;
        rx_ferr  = ferr_q;
        rx_ready = (state_q == ST_DONE);
    end

endmodule

// File: rtl/kbd_rx_hostbits.sv
module kbd_rx_hostbits
    import kbd_rx_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_ready,
    input  logic [DATA_BITS-1:0] rx_byte,
    input  logic                 rx_perr,
    input  logic                 rx_ferr,
    input  logic [ADDR_W-1:0]    bit_addr,
    input  logic                 bit_wr,
    input  logic                 bit_wdata,
    output logic                 bit_rdata,
    output logic                 data_ready,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 int_en,
    output logic                 page_sel,
    output logic                 kbd_int_n
);

    localparam logic [ADDR_W-1:0] A_RDY  = ADDR_W'(IN_RDY_BIT);
    localparam logic [ADDR_W-1:0] A_PERR = ADDR_W'(IN_PERR_BIT);
    localparam logic [ADDR_W-1:0] A_FERR = ADDR_W'(IN_FERR_BIT);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OUT_SEL_BIT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OUT_IEN_BIT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OUT_ACK_BIT);

    logic rdy_q, perr_q, ferr_q, ien_q, sel_q;
    logic ack;

    assign ack = bit_wr && bit_wdata && (bit_addr == A_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ien_q  <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            if (rx_ready) begin
                rdy_q  <= 1'b1;
                perr_q <= rx_perr;
                ferr_q <= rx_ferr;
            end else if (ack) begin
                rdy_q  <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
            end
            if (bit_wr && bit_addr == A_SEL) begin
                sel_q <= bit_wdata;
            end
            if (bit_wr && bit_addr == A_IEN && !sel_q) begin
                ien_q <= bit_wdata;
            end
        end
    end

    always_comb begin
        bit_rdata = 1'b0;
        for (int i = 0; i < DATA_BITS; i++) begin
            if (bit_addr == ADDR_W'(i)) bit_rdata = rx_byte[i];
        end
        if (bit_addr == A_RDY)  bit_rdata = rdy_q;
        if (bit_addr == A_PERR) bit_rdata = perr_q;
        if (bit_addr == A_FERR) bit_rdata = ferr_q;
    end

    assign data_ready = rdy_q;
    assign parity_err = perr_q;
    assign frame_err  = ferr_q;
    assign int_en     = ien_q;
    assign page_sel   = sel_q;
    assign kbd_int_n  = !(rdy_q && ien_q);

endmodule

// File: rtl/kbd_serial_rx_if.sv
module kbd_serial_rx_if #(
    parameter int CLK_DIV   = 27,
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 serial_in,
    input  logic [ADDR_W-1:0]    bit_addr,
    input  logic                 bit_wr,
    input  logic                 bit_wdata,
    output logic                 bit_rdata,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 data_ready,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 kbd_int_n
);

    logic rxd_s;
    logic tick_w;
    logic rx_ready_w;
    logic rx_perr_w;
    logic rx_ferr_w;
    logic int_en_w;
    logic page_sel_w;

    kbd_rx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (serial_in),
        .dout (rxd_s)
    );

    kbd_rx_baud #(.DIV(CLK_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    kbd_rx_core #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd_s),
        .tick    (tick_w),
        .rx_byte (rx_byte),
        .rx_perr (rx_perr_w),
        .rx_ferr (rx_ferr_w),
        .rx_ready(rx_ready_w)
    );

    kbd_rx_hostbits #(.ADDR_W(ADDR_W), .DATA_BITS(DATA_BITS)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ready  (rx_ready_w),
        .rx_byte   (rx_byte),
        .rx_perr   (rx_perr_w),
        .rx_ferr   (rx_ferr_w),
        .bit_addr  (bit_addr),
        .bit_wr    (bit_wr),
        .bit_wdata (bit_wdata),
        .bit_rdata (bit_rdata),
        .data_ready(data_ready),
        .parity_err(parity_err),
        .frame_err (frame_err),
        .int_en    (int_en_w),
        .page_sel  (page_sel_w),
        .kbd_int_n (kbd_int_n)
    );

endmodule

// File: rtl/kbd_rx_chk.sv
module kbd_rx_chk #(
    parameter int ADDR_W    = 5,
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_ready,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 data_ready,
    input logic                 parity_err,
    input logic                 int_en,
    input logic                 page_sel,
    input logic [ADDR_W-1:0]    bit_addr,
    input logic                 bit_wr,
    input logic                 bit_wdata,
    input logic                 bit_rdata,
    input logic                 kbd_int_n
);

    localparam logic [ADDR_W-1:0] A_RDY = ADDR_W'(kbd_rx_pkg::IN_RDY_BIT);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(kbd_rx_pkg::OUT_IEN_BIT);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(kbd_rx_pkg::OUT_ACK_BIT);

    logic ack;
    assign ack = bit_wr && bit_wdata && (bit_addr == A_ACK);

    p_byte_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> $stable(rx_byte));

    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !ack) |=> data_ready);

    p_read_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_addr == A_RDY) |-> (bit_rdata == data_ready));

    p_int_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_int_n |-> (data_ready && int_en));

    p_int_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && int_en) |-> !kbd_int_n);

    p_enable_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && bit_addr == A_IEN && page_sel) |=> $stable(int_en));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rx_ready) |=> (!data_ready && !parity_err));

    p_ready_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> data_ready);

endmodule

bind kbd_serial_rx_if kbd_rx_chk #(.ADDR_W(ADDR_W), .DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ready  (rx_ready_w),
    .rx_byte   (rx_byte),
    .data_ready(data_ready),
    .parity_err(parity_err),
    .int_en    (int_en_w),
    .page_sel  (page_sel_w),
    .bit_addr  (bit_addr),
    .bit_wr    (bit_wr),
    .bit_wdata (bit_wdata),
    .bit_rdata (bit_rdata),
    .kbd_int_n (kbd_int_n)
);

// File: tb/kbd_serial_rx_if_tb.sv
`timescale 1ns/1ps
module kbd_serial_rx_if_tb;

    localparam int DIV     = 4;
    localparam int OVS     = 16;
    localparam int BIT_CLK = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_in = 1'b1;
    logic [4:0] bit_addr = '0;
    logic       bit_wr = 1'b0;
    logic       bit_wdata = 1'b0;
    logic       bit_rdata;
    logic [7:0] rx_byte;
    logic       data_ready, parity_err, frame_err, kbd_int_n;

    int n_run = 0;
    int n_fail = 0;
    bit ien_model = 1'b0;

    always #5 clk = ~clk;

    kbd_serial_rx_if #(.CLK_DIV(DIV), .OVS(OVS), .DATA_BITS(8), .ADDR_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in),
        .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_wdata(bit_wdata),
        .bit_rdata(bit_rdata), .rx_byte(rx_byte), .data_ready(data_ready),
        .parity_err(parity_err), .frame_err(frame_err), .kbd_int_n(kbd_int_n)
    );

    function automatic bit even_par(input logic [7:0] b);
        return ^b;
    endfunction

    function automatic bit exp_int_n(input bit rdy, input bit en);
        return !(rdy && en);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int addr, input bit v);
        @(negedge clk);
        bit_addr = 5'(addr); bit_wdata = v; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
    endtask

    task automatic host_read(input int addr, output bit v);
        @(negedge clk);
        bit_addr = 5'(addr);
        #1 v = bit_rdata;
    endtask

    task automatic drive_bit(input bit v);
        serial_in = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                              input bit hold_ack, output bit seen);
        seen = 1'b0;
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(even_par(b) ^ bad_par);
        if (hold_ack) begin
            bit_addr = 5'd17; bit_wdata = 1'b1; bit_wr = 1'b1;
        end
        serial_in = !bad_stop;
        for (int i = 0; i < BIT_CLK; i++) begin
            @(negedge clk);
            if (data_ready) seen = 1'b1;
        end
        bit_wr = 1'b0;
        serial_in = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic check_frame(input logic [7:0] b, input bit bp, input bit bs);
        bit v;
        check(data_ready == 1'b1, "R3 data_ready set", data_ready, 1);
        check(rx_byte == b, "R1 byte", rx_byte, b);
        check(parity_err == bp, "R7 parity_err", parity_err, bp);
        check(frame_err == bs, "R10 frame_err", frame_err, bs);
        check(kbd_int_n == exp_int_n(1'b1, ien_model), "R5 int", kbd_int_n, exp_int_n(1'b1, ien_model));
        host_read(16, v);
        check(v == 1'b1, "R4 read addr16", v, 1);
        host_read(17, v);
        check(v == bp, "R4 read addr17", v, bp);
        host_read(18, v);
        check(v == bs, "R4 read addr18", v, bs);
        for (int i = 0; i < 8; i++) begin
            host_read(i, v);
            check(v == b[i], "R4 read data bit", v, b[i]);
        end
        host_read(20, v);
        check(v == 1'b0, "R4 unmapped addr", v, 0);
        host_write(17, 1'b1);
        #1;
        check(!data_ready && !parity_err && !frame_err, "R8 ack clears",
              {data_ready, parity_err, frame_err}, 0);
        check(kbd_int_n == 1'b1, "R5 int idle after ack", kbd_int_n, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        bit seen;
        bit v;
        logic [7:0] b;
        bit bp, bs;
        void'($urandom(32'h1d4b));
        repeat (5) @(negedge clk);
        // R12 reset state
        check(!data_ready && !parity_err && !frame_err, "R12 reset flags",
              {data_ready, parity_err, frame_err}, 0);
        check(kbd_int_n == 1'b1, "R12 int idle", kbd_int_n, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        host_read(16, v);
        check(v == 1'b0, "R12 ready bit reads 0", v, 0);

        // R11 glitch shorter than half a bit
        serial_in = 1'b0;
        repeat (BIT_CLK / 4) @(negedge clk);
        serial_in = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        check(data_ready == 1'b0, "R11 glitch rejected", data_ready, 0);

        // R6 enable write blocked while select bit is 1
        host_write(15, 1'b1);
        host_write(16, 1'b1);
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0, seen);
        check(kbd_int_n == 1'b1, "R6 enable locked", kbd_int_n, 1);
        check_frame(8'hA5, 1'b0, 1'b0);

        // R6 enable write accepted with select bit 0
        host_write(15, 1'b0);
        host_write(16, 1'b1);
        ien_model = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0, seen);
        check(kbd_int_n == 1'b0, "R6 R5 enable accepted", kbd_int_n, 0);
        check_frame(8'h3C, 1'b0, 1'b0);

        // Directed corners: all zeros, all ones, bad parity, bad stop
        send_frame(8'h00, 1'b0, 1'b0, 1'b0, seen); check_frame(8'h00, 1'b0, 1'b0);
        send_frame(8'hFF, 1'b1, 1'b0, 1'b0, seen); check_frame(8'hFF, 1'b1, 1'b0);
        send_frame(8'h81, 1'b0, 1'b1, 1'b0, seen); check_frame(8'h81, 1'b0, 1'b1);

        // R9 ready strobe during continuous acknowledge
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1, seen);
        check(seen == 1'b1, "R9 ready beats ack", seen, 1);
        check(data_ready == 1'b0, "R9 then cleared by ack", data_ready, 0);

        // R3 latch holds across idle time
        send_frame(8'h7E, 1'b0, 1'b0, 1'b0, seen);
        repeat (3 * BIT_CLK) @(negedge clk);
        check(data_ready == 1'b1, "R3 latch holds", data_ready, 1);
        check_frame(8'h7E, 1'b0, 1'b0);

        // Random frames
        for (int k = 0; k < 20; k++) begin
            b  = 8'($urandom);
            bp = ($urandom % 4) == 0;
            bs = ($urandom % 5) == 0;
            if (($urandom % 3) == 0) begin
                ien_model = $urandom % 2;
                host_write(16, ien_model);
            end
            send_frame(b, bp, bs, 1'b0, seen);
            check_frame(b, bp, bs);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule